// File: doc/BRIEF.md
# ADC Start-up Offset Calibration Sequencer

This block sequences reset and start-up offset calibration for a multi-channel ADC path. An active-low power-down pin clears the block's whole state at once. That state includes a small bank of control registers, which return to their defaults. When the pin is released, a calibration window opens. The window is measured in sample-rate strobes, not in clock cycles.

While the window is open, three things hold. Every ADC output word reads as two's-complement zero. The input and output gain stages are forced to mute. Any write aimed at the protected control address is discarded, and a sticky flag records each discarded write. The DAC path is not part of the calibration and passes through untouched.

When the window closes, the block issues a one-cycle completion pulse and raises a completion flag. The flag is not affected by the per-block power bits. Only a new low level on the power-down pin clears it. A low level during the window aborts the calibration.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While `pdn_n` is low, the control registers read their defaults: address 2 reads 0x03 and addresses 0, 1 and 3 read 0x00. In the same state `cal_busy`, `cal_valid` and `wr_rejected` are 0.
- R2: `cal_busy` goes high on the first clock edge that samples `pdn_n` high. It falls on the edge that samples the CAL_TICKS-th `fs_tick` strobe, where CAL_TICKS defaults to 4128.
- R3: `cal_done` is high for exactly one cycle, starting on the edge where `cal_busy` falls. `cal_valid` becomes 1 on that same edge.
- R4: While `cal_busy` is high, every channel of `adc_out` is zero, whatever `adc_in` holds.
- R5: Outside calibration, `adc_out` equals `adc_in` when `adc_pwr` is 1 and is zero when `adc_pwr` is 0.
- R6: `in_mute` and `out_mute` are 1 while `cal_busy` is high. Outside calibration they follow bit 0 and bit 1 of register address 2. The default of that register keeps both stages muted after calibration ends.
- R7: A write to address 1 while `cal_busy` is high leaves that register unchanged and sets `wr_rejected`. A write to any other address during calibration takes effect.
- R8: A write to address 1 outside calibration updates the register and leaves `wr_rejected` at 0.
- R9: Once set, `cal_valid` stays 1 whatever `adc_pwr` and `dac_pwr` do. Only a low level on `pdn_n` clears it.
- R10: `dac_out` equals `dac_in` when `dac_pwr` is 1, whether or not calibration is running, and is zero when `dac_pwr` is 0.
- R11: Driving `pdn_n` low during calibration ends the window without a `cal_done` pulse and clears `cal_valid`. The next release runs a full CAL_TICKS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pdn_n | input | 1 | Active-low power-down pin; asynchronous clear of the whole block |
| fs_tick | input | 1 | One-cycle strobe, one per sample period |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| adc_pwr | input | 1 | ADC block power bit |
| dac_pwr | input | 1 | DAC block power bit |
| adc_in | input | 40 | ADC sample words, channel 0 in the low bits |
| dac_in | input | 40 | DAC sample words, channel 0 in the low bits |
| adc_out | output | 40 | Gated ADC sample words |
| dac_out | output | 40 | Gated DAC sample words |
| in_mute | output | 1 | Input gain stage mute |
| out_mute | output | 1 | Output gain stage mute |
| cal_busy | output | 1 | Calibration window open |
| cal_done | output | 1 | One-cycle pulse when the window closes |
| cal_valid | output | 1 | Calibration has completed since the last power-down |
| wr_rejected | output | 1 | Sticky: a write to the protected address was dropped |

## Verification
A window counter that is off by one shows up at once: `cal_busy` falls one strobe early or one strobe late, and `cal_done` moves with it. Because of this, the bench samples the boundary on either side of the CAL_TICKS-th strobe. A corrupted lock decision shows on the next read of address 1 and on `wr_rejected`, one cycle after the write. A sequencer state that fails to clear on power-down, or that reacts to the power bits, shows in `cal_valid` on the very next sample.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [1:0] {
      CS_OFF   = 2'd0,
      CS_CAL   = 2'd1,
      CS_READY = 2'd2
   } cal_state_e;

   // Reset value of control register idx; the mute register starts with both stages muted
   function automatic logic [31:0] reg_default(input int idx, input int mute_idx);
      return (idx == mute_idx) ? 32'h0000_0003 : 32'h0000_0000;
   endfunction

endpackage

// File: rtl/cal_timer.sv
module cal_timer
   import cal_seq_pkg::*;
#(
   parameter int CAL_TICKS = 4128
) (
   input  logic clk,
   input  logic pdn_n,
   input  logic fs_tick,
   output logic busy,
   output logic done,
   output logic valid
);
   localparam int CNT_W = $clog2(CAL_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_TICKS - 1);

   cal_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             last_tick;

   assign last_tick = fs_tick && (cnt == LAST);

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         state <= CS_OFF;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            CS_OFF: begin
               state <= CS_CAL;
               cnt   <= '0;
            end
            CS_CAL: begin
               if (last_tick) begin
                  state <= CS_READY;
                  done  <= 1'b1;
                  cnt   <= '0;
               end else if (fs_tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            CS_READY: state <= CS_READY;
            default:  state <= CS_OFF;
         endcase
      end
   end

   assign busy  = (state == CS_CAL);
   assign valid = (state == CS_READY);

   // R2: the counter never runs past the window
   p_no_overrun_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      busy |-> (cnt <= LAST));

   // R3: the window closes only together with the completion pulse
   p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!pdn_n)
      $fell(busy) |-> done);

   // R3: the completion pulse lasts a single cycle
   p_done_single_r3: assert property (@(posedge clk) disable iff (!pdn_n)
      done |=> !done);

   // R9: completion is sticky until power-down
   p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!pdn_n)
      valid |=> valid);

   // R2: a window never opens after completion without a power-down
   p_busy_not_valid_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      busy |-> !valid);

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
   import cal_seq_pkg::*;
#(
   parameter int NREGS     = 4,
   parameter int DATA_W    = 8,
   parameter int LOCK_ADDR = 1,
   parameter int MUTE_ADDR = 2,
   parameter int ADDR_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              busy,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        mute_bits,
   output logic              wr_rejected
);
   localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

   logic [DATA_W-1:0] regs [NREGS];
   logic              lock_hit;
   logic              wr_ok;

   assign lock_hit = wr_en && busy && (wr_addr == LOCK_A);
   assign wr_ok    = wr_en && !lock_hit && (int'(wr_addr) < NREGS);

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         for (int i = 0; i < NREGS; i++) begin
            regs[i] <= DATA_W'(reg_default(i, MUTE_ADDR));
         end
         wr_rejected <= 1'b0;
      end else begin
         if (wr_ok) begin
            regs[wr_addr] <= wr_data;
         end
         if (lock_hit) begin
            wr_rejected <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < NREGS) begin
         rd_data = regs[rd_addr];
      end
   end

   assign mute_bits = regs[MUTE_ADDR][1:0];

   // R7: a blocked write leaves the protected register untouched
   p_lock_hold_r7: assert property (@(posedge clk) disable iff (!pdn_n)
      lock_hit |=> (regs[LOCK_ADDR] == $past(regs[LOCK_ADDR])));

   // R7: the rejection flag is sticky until power-down
   p_reject_sticky_r7: assert property (@(posedge clk) disable iff (!pdn_n)
      wr_rejected |=> wr_rejected);

   // R8: outside the window the flag is never newly raised
   p_no_reject_idle_r8: assert property (@(posedge clk) disable iff (!pdn_n)
      (!busy && !wr_rejected) |=> !wr_rejected);

endmodule

// File: rtl/sample_gate.sv
module sample_gate #(
   parameter int NCH = 2,
   parameter int SW  = 20
) (
   input  logic              busy,
   input  logic              adc_pwr,
   input  logic              dac_pwr,
   input  logic [NCH*SW-1:0] adc_in,
   input  logic [NCH*SW-1:0] dac_in,
   output logic [NCH*SW-1:0] adc_out,
   output logic [NCH*SW-1:0] dac_out
);
   logic adc_pass;

   assign adc_pass = adc_pwr && !busy;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign adc_out[c*SW +: SW] = adc_pass ? adc_in[c*SW +: SW] : '0;
      assign dac_out[c*SW +: SW] = dac_pwr  ? dac_in[c*SW +: SW] : '0;
   end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
   parameter int CAL_TICKS = 4128,
   parameter int NCH       = 2,
   parameter int SW        = 20,
   parameter int NREGS     = 4,
   parameter int DATA_W    = 8,
   parameter int LOCK_ADDR = 1,
   parameter int MUTE_ADDR = 2,
   parameter int ADDR_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              fs_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              adc_pwr,
   input  logic              dac_pwr,
   input  logic [NCH*SW-1:0] adc_in,
   input  logic [NCH*SW-1:0] dac_in,
   output logic [NCH*SW-1:0] adc_out,
   output logic [NCH*SW-1:0] dac_out,
   output logic              in_mute,
   output logic              out_mute,
   output logic              cal_busy,
   output logic              cal_done,
   output logic              cal_valid,
   output logic              wr_rejected
);
   if (CAL_TICKS < 2) begin : g_bad_ticks
      $error("cal_seq_ctrl: CAL_TICKS must be at least 2");
   end
   if (NCH < 1 || SW < 1) begin : g_bad_path
      $error("cal_seq_ctrl: NCH and SW must be positive");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("cal_seq_ctrl: DATA_W must hold both mute bits");
   end
   if (LOCK_ADDR >= NREGS || MUTE_ADDR >= NREGS || LOCK_ADDR == MUTE_ADDR) begin : g_bad_addr
      $error("cal_seq_ctrl: lock and mute addresses must be distinct and in range");
   end
   if (ADDR_W < 1 || (1 << ADDR_W) < NREGS) begin : g_bad_aw
      $error("cal_seq_ctrl: ADDR_W too narrow for NREGS");
   end

   logic [1:0] mute_bits;

   cal_timer #(
      .CAL_TICKS(CAL_TICKS)
   ) u_timer (
      .clk    (clk),
      .pdn_n  (pdn_n),
      .fs_tick(fs_tick),
      .busy   (cal_busy),
      .done   (cal_done),
      .valid  (cal_valid)
   );

   ctrl_regs #(
      .NREGS    (NREGS),
      .DATA_W   (DATA_W),
      .LOCK_ADDR(LOCK_ADDR),
      .MUTE_ADDR(MUTE_ADDR),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .pdn_n      (pdn_n),
      .busy       (cal_busy),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .mute_bits  (mute_bits),
      .wr_rejected(wr_rejected)
   );

   sample_gate #(
      .NCH(NCH),
      .SW (SW)
   ) u_gate (
      .busy   (cal_busy),
      .adc_pwr(adc_pwr),
      .dac_pwr(dac_pwr),
      .adc_in (adc_in),
      .dac_in (dac_in),
      .adc_out(adc_out),
      .dac_out(dac_out)
   );

   assign in_mute  = cal_busy | mute_bits[0];
   assign out_mute = cal_busy | mute_bits[1];

   // R4: the gate output seen from the timer's window is silent
   p_zero_in_cal_r4: assert property (@(posedge clk) disable iff (!pdn_n)
      cal_busy |-> (adc_out == '0));

   // R11: no completion pulse follows a window that is still open
   p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!pdn_n)
      cal_done |-> !cal_busy && cal_valid);

endmodule

// File: tb/cal_seq_ctrl_bench.sv
module cal_seq_ctrl_bench;
   localparam int CT = 4128;
   localparam int W  = 40;

   logic          clk = 1'b0;
   logic          pdn_n = 1'b0;
   logic          fs_tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [7:0]    rd_data;
   logic          adc_pwr = 1'b1;
   logic          dac_pwr = 1'b1;
   logic [W-1:0]  adc_in = '0;
   logic [W-1:0]  dac_in = '0;
   logic [W-1:0]  adc_out;
   logic [W-1:0]  dac_out;
   logic          in_mute, out_mute, cal_busy, cal_done, cal_valid, wr_rejected;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   cal_seq_ctrl u_cal_seq_ctrl (
      .clk(clk), .pdn_n(pdn_n), .fs_tick(fs_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .adc_pwr(adc_pwr), .dac_pwr(dac_pwr), .adc_in(adc_in), .dac_in(dac_in),
      .adc_out(adc_out), .dac_out(dac_out), .in_mute(in_mute), .out_mute(out_mute),
      .cal_busy(cal_busy), .cal_done(cal_done), .cal_valid(cal_valid),
      .wr_rejected(wr_rejected)
   );

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic give_tick();
      @(negedge clk);
      fs_tick = 1'b1;
      @(negedge clk);
      fs_tick = 1'b0;
   endtask

   task automatic give_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         give_tick();
         step(2);
      end
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_check(input string what, input logic [1:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      check(what, rd_data, exp);
   endtask

   task automatic t_reset();
      pdn_n = 1'b0;
      step(3);
      check("R1 busy in reset", cal_busy, 0);
      check("R1 valid in reset", cal_valid, 0);
      check("R1 rejected in reset", wr_rejected, 0);
      read_check("R1 reg0 default", 2'd0, 8'h00);
      read_check("R1 reg1 default", 2'd1, 8'h00);
      read_check("R1 reg2 default", 2'd2, 8'h03);
      read_check("R1 reg3 default", 2'd3, 8'h00);
   endtask

   task automatic t_full_cal();
      adc_in = 40'h12345_ABCDE;
      dac_in = 40'h0F0F0_55555;
      adc_pwr = 1'b1; dac_pwr = 1'b1;
      @(negedge clk);
      pdn_n = 1'b1;
      @(negedge clk);
      check("R2 busy after release", cal_busy, 1);
      check("R4 adc zero in cal", adc_out, 0);
      check("R6 in_mute in cal", in_mute, 1);
      check("R6 out_mute in cal", out_mute, 1);
      check("R10 dac passes in cal", dac_out, dac_in);
      adc_in = 40'hFFFFF_80000;
      #1;
      check("R4 adc zero, new input", adc_out, 0);
      give_ticks(CT - 1);
      check("R2 busy before last tick", cal_busy, 1);
      check("R3 no done early", cal_done, 0);
      check("R3 not valid early", cal_valid, 0);
      give_tick();
      check("R2 busy falls on last tick", cal_busy, 0);
      check("R3 done pulse", cal_done, 1);
      check("R3 valid set", cal_valid, 1);
      @(negedge clk);
      check("R3 done single cycle", cal_done, 0);
      check("R5 adc passes after cal", adc_out, adc_in);
      check("R6 in_mute stays after cal", in_mute, 1);
      check("R6 out_mute stays after cal", out_mute, 1);
   endtask

   task automatic t_after();
      write_reg(2'd1, 8'hA5);
      read_check("R8 lock addr write idle", 2'd1, 8'hA5);
      check("R8 no rejection idle", wr_rejected, 0);
      adc_pwr = 1'b0;
      step(2);
      check("R5 adc zero when unpowered", adc_out, 0);
      check("R9 valid with adc off", cal_valid, 1);
      dac_pwr = 1'b0;
      step(2);
      check("R10 dac zero when unpowered", dac_out, 0);
      check("R9 valid with both off", cal_valid, 1);
      adc_pwr = 1'b1; dac_pwr = 1'b1;
      step(1);
      check("R9 valid after repower", cal_valid, 1);
      check("R10 dac passes", dac_out, dac_in);
      write_reg(2'd2, 8'h02);
      #1;
      check("R6 in_mute follows bit0", in_mute, 0);
      check("R6 out_mute follows bit1", out_mute, 1);
   endtask

   task automatic t_abort();
      @(negedge clk);
      pdn_n = 1'b0;
      step(2);
      check("R1 valid cleared", cal_valid, 0);
      read_check("R1 reg1 back to default", 2'd1, 8'h00);
      read_check("R1 reg2 back to default", 2'd2, 8'h03);
      pdn_n = 1'b1;
      @(negedge clk);
      check("R11 busy on new release", cal_busy, 1);
      write_reg(2'd1, 8'h5A);
      read_check("R7 lock addr unchanged", 2'd1, 8'h00);
      check("R7 rejected set", wr_rejected, 1);
      write_reg(2'd3, 8'h3C);
      read_check("R7 other addr accepted", 2'd3, 8'h3C);
      write_reg(2'd2, 8'h00);
      #1;
      check("R6 mute forced despite reg", in_mute & out_mute, 1);
      give_ticks(100);
      @(negedge clk);
      pdn_n = 1'b0;
      #1;
      check("R11 busy cleared on abort", cal_busy, 0);
      check("R11 no done on abort", cal_done, 0);
      check("R11 valid clear on abort", cal_valid, 0);
      check("R1 rejected cleared", wr_rejected, 0);
      step(2);
      pdn_n = 1'b1;
      @(negedge clk);
      give_ticks(CT - 1);
      check("R11 full window after abort", cal_busy, 1);
      give_tick();
      check("R11 done after full window", cal_done, 1);
      check("R11 busy ends after full window", cal_busy, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      t_reset();
      t_full_cal();
      t_after();
      t_abort();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule